// File: doc/BRIEF.md
# Independent Request Bus Arbiter

This block is the central controller of a shared bus used by several masters. Each unit has its own request line into the controller and its own grant line back out. The bus also carries a single busy line that the current master drives. While the bus is free, the controller looks at every request line, picks one winner by fixed priority and raises that unit's grant. Bus ownership changes hands only through this controller. Units never pass ownership to each other.

Once a grant is out, the controller waits for the granted unit to take the bus by raising busy. If that happens, the grant is dropped, and the owner index stays on the output until the owner lets busy fall. If the unit never takes the bus, the grant is withdrawn after a programmable number of cycles. It is also withdrawn if the unit drops its request first. Either way, arbitration then starts again. After the owner lets busy fall, the controller keeps the bus idle for one cycle before it issues the next grant.

Top module: `bus_arbiter_ir`

## Requirements
- R1: While rst_n is low at a rising clock edge, grant becomes all zeros and grant_idx becomes 0 after that edge.
- R2: A grant bit rises only for a unit whose request was high at the edge where the grant was issued.
- R3: With the controller free and busy low, a pending request set is granted one edge later, to the requesting unit with the lowest index.
- R4: grant is one-hot or zero. Whenever it is non-zero, grant_idx holds the binary index of its set bit.
- R5: At an edge where busy is sampled high, no grant is issued. After any such edge, grant is zero.
- R6: The grant stays high until the edge that samples busy high. From then on, grant_idx keeps the owner's index while busy stays high.
- R7: A grant that is not answered by busy stays high for exactly GRANT_TIMEOUT cycles and is then withdrawn. If the unit is still requesting, it is granted again after one cycle with no grant.
- R8: If the granted unit drops its request while busy is low, the grant is withdrawn at the next edge. At the following edge, the lowest-index unit still requesting is granted.
- R9: After the owner's busy is first sampled low, there is one further edge with no grant. A waiting request is granted only at the edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N_UNITS | One request line per unit, bit i for unit i |
| busy | input | 1 | Shared line driven high by the master using the bus |
| grant | output | N_UNITS | One-hot grant lines, bit i for unit i, registered |
| grant_idx | output | IDX_W | Index of the last granted unit; holds the owner while busy |

## Verification
The bench builds the arbiter with four units and a grant timeout of three cycles. Four units make all fifteen non-empty request patterns a short sweep. That sweep covers every priority outcome, both with busy low and with busy already high. The short timeout lets the withdraw-and-regrant path be counted cycle by cycle. The same patterns also drive the request-drop path, the release gap and a reset taken in the middle of a grant.

// File: rtl/arb_ir_pkg.sv
// Shared types of the independent request bus arbiter.
package arb_ir_pkg;
    // Controller phase: free, grant offered, bus owned.
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_OWNED = 2'd2
    } arb_phase_e;
endpackage

// File: rtl/fixed_prio_pick.sv
// Fixed-priority winner pick: the lowest-index asserted request wins.
// Assumes N_UNITS >= 1. Purely combinational.
module fixed_prio_pick #(
    parameter int N_UNITS = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_UNITS-1:0] req,
    output logic [N_UNITS-1:0] win_onehot,
    output logic [IDX_W-1:0]   win_idx,
    output logic               any_req
);
    logic [N_UNITS:0] lower_seen;

    assign lower_seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N_UNITS; g++) begin : g_chain
            // Unit g wins when it requests and no lower unit does.
            assign win_onehot[g]   = req[g] & ~lower_seen[g];
            assign lower_seen[g+1] = lower_seen[g] | req[g];
        end
    endgenerate

    assign any_req = lower_seen[N_UNITS];

    // Encode the one-hot winner into a binary index.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (win_onehot[i]) win_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/offer_timer.sv
// Counts the cycles that a grant has been offered without an answer.
// Assumes LIMIT >= 1. It counts while run is high and clears otherwise.
module offer_timer #(
    parameter int LIMIT = 8,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CNT_W-1:0] cnt_q;

    // Cycle counter for the current offer.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/bus_arbiter_ir.sv
// Central bus controller with one request line and one grant line per unit.
// When busy is low it grants the lowest-index requester. It withdraws the
// grant when busy is taken, when the request drops or when the timeout
// runs out. Assumes busy is driven only by the unit holding the grant or
// the bus.
module bus_arbiter_ir
    import arb_ir_pkg::*;
#(
    parameter int N_UNITS       = 4,
    parameter int GRANT_TIMEOUT = 8,
    parameter int IDX_W         = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] req,
    input  logic               busy,
    output logic [N_UNITS-1:0] grant,
    output logic [IDX_W-1:0]   grant_idx
);
    localparam int CNT_W = $clog2(GRANT_TIMEOUT + 1) + 1;

    arb_phase_e         phase_q;
    logic [N_UNITS-1:0] grant_q;
    logic [IDX_W-1:0]   idx_q;
    logic [N_UNITS-1:0] pick_onehot;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_any;
    logic               offer_expired;
    logic               owner_req;

    fixed_prio_pick #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_pick (
        .req        (req),
        .win_onehot (pick_onehot),
        .win_idx    (pick_idx),
        .any_req    (pick_any)
    );

    offer_timer #(.LIMIT(GRANT_TIMEOUT), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (phase_q == ST_OFFER),
        .expired (offer_expired)
    );

    // The granted unit still holds its request.
    assign owner_req = |(req & grant_q);

    // Phase sequencing and registered grant and owner index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ST_FREE;
            grant_q <= '0;
            idx_q   <= '0;
        end else begin
            case (phase_q)
                ST_FREE: begin
                    if (!busy && pick_any) begin
                        grant_q <= pick_onehot;
                        idx_q   <= pick_idx;
                        phase_q <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (busy) begin
                        grant_q <= '0;
                        phase_q <= ST_OWNED;
                    end else if (!owner_req || offer_expired) begin
                        grant_q <= '0;
                        phase_q <= ST_FREE;
                    end
                end
                ST_OWNED: begin
                    if (!busy) phase_q <= ST_FREE;
                end
                default: begin
                    grant_q <= '0;
                    phase_q <= ST_FREE;
                end
            endcase
        end
    end

    assign grant     = grant_q;
    assign grant_idx = idx_q;
endmodule

// File: rtl/bus_arbiter_ir_chk.sv
// Protocol checker for bus_arbiter_ir, bound to every instance.
// It watches only the ports. A counter tracks the length of grant runs.
module bus_arbiter_ir_chk #(
    parameter int N_UNITS       = 4,
    parameter int GRANT_TIMEOUT = 8,
    parameter int IDX_W         = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_UNITS-1:0] req,
    input logic               busy,
    input logic [N_UNITS-1:0] grant,
    input logic [IDX_W-1:0]   grant_idx
);
    localparam int RUN_W = $clog2(GRANT_TIMEOUT + 2) + 1;

    logic [RUN_W-1:0] run_len;

    // Length of the current unbroken grant run.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_len <= '0;
        else if (|grant)   run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !$past(|grant)) |-> ((grant & $past(req)) == grant));

    // R3
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !$past(|grant)) |-> (((grant - 1'b1) & $past(req)) == '0));

    // R4
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|grant) -> grant[grant_idx]));

    // R5
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (grant == '0));

    // R6
    owner_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(grant_idx));

    // R7
    grant_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RUN_W'(GRANT_TIMEOUT));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && ((req & grant) == '0) && !busy) |=> (grant == '0));
endmodule

bind bus_arbiter_ir bus_arbiter_ir_chk #(
    .N_UNITS       (N_UNITS),
    .GRANT_TIMEOUT (GRANT_TIMEOUT),
    .IDX_W         (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .busy      (busy),
    .grant     (grant),
    .grant_idx (grant_idx)
);

// File: tb/bus_arbiter_ir_tb.sv
// Bench: four units, timeout of three cycles, sweep of all request patterns.
module bus_arbiter_ir_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int TMO        = 3;
    localparam int IW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          busy = 1'b0;
    logic [N-1:0]  grant;
    logic [IW-1:0] grant_idx;

    int n_checks = 0;
    int n_errors = 0;

    bus_arbiter_ir #(.N_UNITS(N), .GRANT_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .busy(busy),
        .grant(grant), .grant_idx(grant_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance past one rising edge. Inputs and checks fall 1 time unit later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic check_grant(input string tag, input int unit);
        check(tag, 32'(grant), 32'(1) << unit);
        check({tag, " idx R4"}, 32'(grant_idx), 32'(unit));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        step(); step();
        check("R1 reset grant", 32'(grant), 0);
        check("R1 reset idx", 32'(grant_idx), 0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", 32'(grant), 0);

        // Sweep: bus free, then ownership taken and released.
        for (int p = 1; p < (1 << N); p++) begin
            req = N'(p);
            step();
            check_grant("R3 priority grant", lowest(N'(p)));
            step();
            check_grant("R6 grant held", lowest(N'(p)));
            busy = 1'b1;
            step();
            check("R6 grant dropped on busy", 32'(grant), 0);
            step();
            check("R5 no grant while busy", 32'(grant), 0);
            check("R6 owner idx held", 32'(grant_idx), 32'(lowest(N'(p))));
            busy = 1'b0;
            step();
            check("R9 gap after release", 32'(grant), 0);
            step();
            check_grant("R9 regrant after gap", lowest(N'(p)));
            req = '0;
            step();
            check("R8 withdraw on drop", 32'(grant), 0);
        end

        // Sweep: busy already high in the free phase blocks the grant.
        for (int p = 1; p < (1 << N); p++) begin
            req = N'(p);
            busy = 1'b1;
            step();
            check("R5 blocked by busy", 32'(grant), 0);
            busy = 1'b0;
            step();
            check_grant("R2 grant after busy low", lowest(N'(p)));
            req = N'(p) & ~(N'(1) << lowest(N'(p)));
            step();
            check("R8 drop withdraws", 32'(grant), 0);
            if (req != '0) begin
                step();
                check_grant("R8 next requester", lowest(req));
                req = '0;
                step();
                check("R8 final withdraw", 32'(grant), 0);
            end
            step();
        end

        // Timeout: grant stays for TMO cycles, then one empty cycle, then regrant.
        req = 4'b0100;
        step();
        for (int k = 0; k < TMO; k++) begin
            check_grant("R7 grant during offer", 2);
            if (k < TMO - 1) step();
        end
        step();
        check("R7 withdrawn at timeout", 32'(grant), 0);
        step();
        check_grant("R7 regrant after timeout", 2);

        // A request from a unit that is not granted does not move the grant.
        req = 4'b0101;
        step();
        check_grant("R2 lower arrival no preemption", 2);

        // Reset in the middle of a grant.
        rst_n = 1'b0;
        step();
        check("R1 reset mid grant", 32'(grant), 0);
        check("R1 reset mid idx", 32'(grant_idx), 0);
        rst_n = 1'b1;
        step();
        check_grant("R3 grant after reset", 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule